// File: doc/BRIEF.md
# IQ Capture Trigger Selector

This block watches the status signals of a WiFi baseband receive and transmit chain and turns one of 32 selectable event conditions into a single-cycle trigger pulse. A sample-capture engine downstream uses the pulse to freeze a window of I/Q history around the moment of interest. The condition is picked by a 5-bit select input from the configuration registers. Two threshold inputs also come from there: one for RSSI, which doubles as the amplitude threshold for the other antenna's I/Q, and one for the AGC gain.

The event sources are the following:
- checksum-result strobes from the receiver (frame check and SIGNAL field) with pass, fail and HT qualifiers;
- preamble-detect strobes;
- threshold crossings of RSSI and AGC gain;
- transitions of the AGC lock flag;
- transmit start and done strobes;
- edges of the baseband-busy and RF-busy levels, optionally gated by an ACK-needed flag;
- amplitude and demodulation coincidences.

Edge and crossing history is kept inside the block. The selected condition is registered once before it leaves.

Top module: `iq_trig_select`

## Requirements
- R1: With select 0 the trigger follows any frame-check strobe (`fcs_stb`). With select 1 it follows only a strobe with `fcs_pass`=1, and with select 2 only a strobe with `fcs_pass`=0.
- R2: Selects 3, 4 and 5 do the same for the SIGNAL strobe (`sig_stb`, `sig_pass`): any result, pass only, fail only. Select 6 fires on a SIGNAL strobe with `sig_ht`=1 and select 7 on a SIGNAL strobe with `sig_ht`=0.
- R3: Select 8 fires on `pre_long` and select 9 on `pre_short`.
- R4: Select 10 fires in the first cycle in which `rssi` > `cfg_rssi_th`. Select 11 fires in the first cycle in which `rssi` < `cfg_rssi_th`. Equality counts as neither. Each comparison is set against its own result from the previous cycle, made with the threshold in force then.
- R5: `agc_word` bit 7 is the lock flag and bits 6:0 are the gain. Select 12 fires on a lock 1-to-0 transition and select 13 on a 0-to-1 transition.
- R6: Select 14 fires in the first cycle in which gain > `cfg_gain_th`. Select 15 fires in the first cycle in which gain < `cfg_gain_th`. Both are crossings in the same sense as R4.
- R7: Select 16 fires on `tx_start` and select 17 on `tx_done`. Select 18 fires on a rising edge of `tx_bb_busy` and 19 on a falling edge. Select 20 fires on a rising edge of `tx_rf_busy` and 21 on a falling edge.
- R8: Selects 22 to 27 give the event of select minus 6, but only in a cycle where `tx_need_ack`=1.
- R9: Select 28 fires in every cycle where `tx_bb_busy`=1 and `alt_amp` > `cfg_rssi_th`, zero-extended. Select 29 does the same with `tx_rf_busy`.
- R10: Select 30 fires when `tx_start` coincides with `rx_demod_busy`. Select 31 fires in every cycle where `rx_demod_busy` and `tx_bb_busy` are both 1.
- R11: `trig` is 0 during reset. It shows the condition selected by the current `cfg_sel` for the inputs of cycle k in cycle k+1. All edge and crossing history resets to 0, so a level or comparison already true in the first cycle after reset counts as a new edge or crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 5 | Condition select |
| cfg_rssi_th | input | 11 | RSSI threshold, also the amplitude threshold |
| cfg_gain_th | input | 7 | AGC gain threshold |
| fcs_stb | input | 1 | Frame-check result strobe |
| fcs_pass | input | 1 | Frame-check outcome, 1 = pass |
| sig_stb | input | 1 | SIGNAL field result strobe |
| sig_pass | input | 1 | SIGNAL field outcome, 1 = pass |
| sig_ht | input | 1 | Packet is HT |
| pre_long | input | 1 | Long preamble detected strobe |
| pre_short | input | 1 | Short preamble detected strobe |
| rssi | input | 11 | RSSI in half-dB steps, uncalibrated |
| agc_word | input | 8 | AGC status: bit 7 lock, bits 6:0 gain |
| tx_start | input | 1 | Transmit started strobe |
| tx_done | input | 1 | Transmit finished strobe |
| tx_bb_busy | input | 1 | Baseband transmit ongoing level |
| tx_rf_busy | input | 1 | RF transmit ongoing level |
| tx_need_ack | input | 1 | Current transmit packet expects an ACK |
| alt_amp | input | 16 | I/Q amplitude of the other antenna |
| rx_demod_busy | input | 1 | Demodulation ongoing level |
| trig | output | 1 | Registered capture trigger pulse |

## Verification
Every result appears on `trig` exactly one clock after the inputs that cause it, because the only register between the inputs and the output is the output flop. Edge and crossing history settles at the same edge, so it affects the comparison of the following cycle. The bench drives a new input set at each falling edge. It compares `trig` at the next falling edge with the value its own model predicted for that input set, then folds the driven values into the model's history. Every select value is swept with dense stimulus around three threshold settings: mid-range, zero and full scale.

// File: rtl/iq_trig_pkg.sv
package iq_trig_pkg;
    localparam int SEL_W    = 5;
    localparam int NUM_COND = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        TS_FCS_ANY, TS_FCS_OK, TS_FCS_BAD,
        TS_SIG_ANY, TS_SIG_OK, TS_SIG_BAD, TS_SIG_HT, TS_SIG_LEG,
        TS_PRE_LONG, TS_PRE_SHORT,
        TS_RSSI_UP, TS_RSSI_DN,
        TS_LOCK_LOST, TS_LOCK_GOT,
        TS_GAIN_UP, TS_GAIN_DN,
        TS_TX_START, TS_TX_DONE,
        TS_BB_RISE, TS_BB_FALL, TS_RF_RISE, TS_RF_FALL,
        TS_ACK_START, TS_ACK_DONE,
        TS_ACK_BB_RISE, TS_ACK_BB_FALL, TS_ACK_RF_RISE, TS_ACK_RF_FALL,
        TS_BB_AMP, TS_RF_AMP,
        TS_DEMOD_TXSTART, TS_DEMOD_BB
    } trig_sel_e;

    // bit positions in the level-edge detector vector
    localparam int E_BB   = 0;
    localparam int E_RF   = 1;
    localparam int E_LOCK = 2;
    localparam int E_NUM  = 3;

    typedef struct packed {
        logic hi;
        logic lo;
    } cross_st_t;
endpackage

// File: rtl/iq_trig_edge.sv
module iq_trig_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/iq_trig_cross.sv
module iq_trig_cross
    import iq_trig_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] val,
    input  logic [W-1:0] th,
    output logic         up,
    output logic         dn
);
    cross_st_t st_d, st_q;

    always_comb begin
        st_d.hi = (val > th);
        st_d.lo = (val < th);
        up      = st_d.hi & ~st_q.hi;
        dn      = st_d.lo & ~st_q.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/iq_trig_events.sv
module iq_trig_events
    import iq_trig_pkg::*;
#(
    parameter int RSSI_W = 11,
    parameter int AMP_W  = 16
) (
    input  logic              fcs_stb,
    input  logic              fcs_pass,
    input  logic              sig_stb,
    input  logic              sig_pass,
    input  logic              sig_ht,
    input  logic              pre_long,
    input  logic              pre_short,
    input  logic              rssi_up,
    input  logic              rssi_dn,
    input  logic              gain_up,
    input  logic              gain_dn,
    input  logic [E_NUM-1:0]  rise,
    input  logic [E_NUM-1:0]  fall,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              tx_bb_busy,
    input  logic              tx_rf_busy,
    input  logic              tx_need_ack,
    input  logic [AMP_W-1:0]  alt_amp,
    input  logic [RSSI_W-1:0] rssi_th,
    input  logic              rx_demod_busy,
    output logic [NUM_COND-1:0] ev
);
    localparam int CMP_W = (AMP_W > RSSI_W) ? AMP_W : RSSI_W;

    logic [CMP_W-1:0] amp_ext, th_ext;
    logic             amp_hi;
    logic [5:0]       tx_ev;

    always_comb begin
        amp_ext = CMP_W'(alt_amp);
        th_ext  = CMP_W'(rssi_th);
        amp_hi  = (amp_ext > th_ext);

        tx_ev = {fall[E_RF], rise[E_RF], fall[E_BB], rise[E_BB], tx_done, tx_start};

        ev = '0;
        ev[TS_FCS_ANY]   = fcs_stb;
        ev[TS_FCS_OK]    = fcs_stb & fcs_pass;
        ev[TS_FCS_BAD]   = fcs_stb & ~fcs_pass;
        ev[TS_SIG_ANY]   = sig_stb;
        ev[TS_SIG_OK]    = sig_stb & sig_pass;
        ev[TS_SIG_BAD]   = sig_stb & ~sig_pass;
        ev[TS_SIG_HT]    = sig_stb & sig_ht;
        ev[TS_SIG_LEG]   = sig_stb & ~sig_ht;
        ev[TS_PRE_LONG]  = pre_long;
        ev[TS_PRE_SHORT] = pre_short;
        ev[TS_RSSI_UP]   = rssi_up;
        ev[TS_RSSI_DN]   = rssi_dn;
        ev[TS_LOCK_LOST] = fall[E_LOCK];
        ev[TS_LOCK_GOT]  = rise[E_LOCK];
        ev[TS_GAIN_UP]   = gain_up;
        ev[TS_GAIN_DN]   = gain_dn;
        for (int i = 0; i < 6; i++) begin
            ev[int'(TS_TX_START) + i]  = tx_ev[i];
            ev[int'(TS_ACK_START) + i] = tx_ev[i] & tx_need_ack;
        end
        ev[TS_BB_AMP]        = tx_bb_busy & amp_hi;
        ev[TS_RF_AMP]        = tx_rf_busy & amp_hi;
        ev[TS_DEMOD_TXSTART] = rx_demod_busy & tx_start;
        ev[TS_DEMOD_BB]      = rx_demod_busy & tx_bb_busy;
    end
endmodule

// File: rtl/iq_trig_select.sv
module iq_trig_select
    import iq_trig_pkg::*;
#(
    parameter int RSSI_W = 11,
    parameter int GAIN_W = 7,
    parameter int AMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [RSSI_W-1:0] cfg_rssi_th,
    input  logic [GAIN_W-1:0] cfg_gain_th,
    input  logic              fcs_stb,
    input  logic              fcs_pass,
    input  logic              sig_stb,
    input  logic              sig_pass,
    input  logic              sig_ht,
    input  logic              pre_long,
    input  logic              pre_short,
    input  logic [RSSI_W-1:0] rssi,
    input  logic [GAIN_W:0]   agc_word,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              tx_bb_busy,
    input  logic              tx_rf_busy,
    input  logic              tx_need_ack,
    input  logic [AMP_W-1:0]  alt_amp,
    input  logic              rx_demod_busy,
    output logic              trig
);
    localparam int LOCK_BIT = GAIN_W;

    logic [E_NUM-1:0]    lvl, rise, fall;
    logic                rssi_up, rssi_dn, gain_up, gain_dn;
    logic [NUM_COND-1:0] ev;
    logic                trig_d, trig_q;

    always_comb begin
        lvl         = '0;
        lvl[E_BB]   = tx_bb_busy;
        lvl[E_RF]   = tx_rf_busy;
        lvl[E_LOCK] = agc_word[LOCK_BIT];
    end

    iq_trig_edge #(.N(E_NUM)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
    );

    iq_trig_cross #(.W(RSSI_W)) u_rssi_x (
        .clk(clk), .rst_n(rst_n), .val(rssi), .th(cfg_rssi_th),
        .up(rssi_up), .dn(rssi_dn)
    );

    iq_trig_cross #(.W(GAIN_W)) u_gain_x (
        .clk(clk), .rst_n(rst_n), .val(agc_word[GAIN_W-1:0]), .th(cfg_gain_th),
        .up(gain_up), .dn(gain_dn)
    );

    iq_trig_events #(.RSSI_W(RSSI_W), .AMP_W(AMP_W)) u_events (
        .fcs_stb(fcs_stb), .fcs_pass(fcs_pass),
        .sig_stb(sig_stb), .sig_pass(sig_pass), .sig_ht(sig_ht),
        .pre_long(pre_long), .pre_short(pre_short),
        .rssi_up(rssi_up), .rssi_dn(rssi_dn),
        .gain_up(gain_up), .gain_dn(gain_dn),
        .rise(rise), .fall(fall),
        .tx_start(tx_start), .tx_done(tx_done),
        .tx_bb_busy(tx_bb_busy), .tx_rf_busy(tx_rf_busy),
        .tx_need_ack(tx_need_ack), .alt_amp(alt_amp),
        .rssi_th(cfg_rssi_th), .rx_demod_busy(rx_demod_busy),
        .ev(ev)
    );

    always_comb begin
        trig_d = ev[cfg_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    assign trig = trig_q;
endmodule

// File: rtl/iq_trig_select_chk.sv
module iq_trig_select_chk
    import iq_trig_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] cfg_sel,
    input logic             fcs_stb,
    input logic             fcs_pass,
    input logic             pre_long,
    input logic             tx_need_ack,
    input logic             tx_bb_busy,
    input logic             rx_demod_busy,
    input logic             trig
);
    // R1
    fcs_any_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == TS_FCS_ANY && fcs_stb) |=> trig);

    // R1
    fcs_bad_quiet_on_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == TS_FCS_BAD && fcs_stb && fcs_pass) |=> !trig);

    // R3
    pre_long_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == TS_PRE_LONG && !pre_long) |=> !trig);

    // R8
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel >= TS_ACK_START && cfg_sel <= TS_ACK_RF_FALL && !tx_need_ack) |=> !trig);

    // R10
    demod_bb_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == TS_DEMOD_BB && rx_demod_busy && tx_bb_busy) |=> trig);
endmodule

bind iq_trig_select iq_trig_select_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel),
    .fcs_stb(fcs_stb), .fcs_pass(fcs_pass), .pre_long(pre_long),
    .tx_need_ack(tx_need_ack), .tx_bb_busy(tx_bb_busy),
    .rx_demod_busy(rx_demod_busy), .trig(trig)
);

// File: tb/tb_iq_trig_select.sv
module tb_iq_trig_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel = '0;
    logic [10:0] rth = '0;
    logic [6:0]  gth = '0;
    logic fcs_v = 0, fcs_ok = 0, sig_v = 0, sig_ok = 0, sig_ht = 0, lpre = 0, spre = 0;
    logic [10:0] rssi = '0;
    logic [7:0]  agc = '0;
    logic txs = 0, txd = 0, bb = 0, rf = 0, ack = 0, demod = 0;
    logic [15:0] amp = '0;
    logic        trig;

    int checks = 0, failures = 0;
    bit done = 0;
    bit p_bb = 0, p_rf = 0, p_lock = 0, p_rhi = 0, p_rlo = 0, p_ghi = 0, p_glo = 0;
    bit exp_q = 0;
    int exp_sel = 0;

    always #5 clk = ~clk;

    iq_trig_select dut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(sel), .cfg_rssi_th(rth), .cfg_gain_th(gth),
        .fcs_stb(fcs_v), .fcs_pass(fcs_ok), .sig_stb(sig_v), .sig_pass(sig_ok),
        .sig_ht(sig_ht), .pre_long(lpre), .pre_short(spre), .rssi(rssi),
        .agc_word(agc), .tx_start(txs), .tx_done(txd), .tx_bb_busy(bb),
        .tx_rf_busy(rf), .tx_need_ack(ack), .alt_amp(amp),
        .rx_demod_busy(demod), .trig(trig)
    );

    function automatic string req_of(int s);
        if (s <= 2)  return "R1";
        if (s <= 7)  return "R2";
        if (s <= 9)  return "R3";
        if (s <= 11) return "R4";
        if (s <= 13) return "R5";
        if (s <= 15) return "R6";
        if (s <= 21) return "R7";
        if (s <= 27) return "R8";
        if (s <= 29) return "R9";
        return "R10";
    endfunction

    // expected event for the inputs currently driven, from the requirement table
    function automatic bit exp_ev(int s);
        bit lock = agc[7];
        int gain = int'(agc[6:0]);
        bit rhi = int'(rssi) > int'(rth);
        bit rlo = int'(rssi) < int'(rth);
        bit ghi = gain > int'(gth);
        bit glo = gain < int'(gth);
        bit ahi = int'(amp) > int'(rth);
        case (s)
            0:  return fcs_v;
            1:  return fcs_v & fcs_ok;
            2:  return fcs_v & !fcs_ok;
            3:  return sig_v;
            4:  return sig_v & sig_ok;
            5:  return sig_v & !sig_ok;
            6:  return sig_v & sig_ht;
            7:  return sig_v & !sig_ht;
            8:  return lpre;
            9:  return spre;
            10: return rhi & !p_rhi;
            11: return rlo & !p_rlo;
            12: return !lock & p_lock;
            13: return lock & !p_lock;
            14: return ghi & !p_ghi;
            15: return glo & !p_glo;
            16: return txs;
            17: return txd;
            18: return bb & !p_bb;
            19: return !bb & p_bb;
            20: return rf & !p_rf;
            21: return !rf & p_rf;
            28: return bb & ahi;
            29: return rf & ahi;
            30: return demod & txs;
            31: return demod & bb;
            default: return ack & exp_ev(s - 6);
        endcase
    endfunction

    task automatic upd_prev();
        p_bb = bb; p_rf = rf; p_lock = agc[7];
        p_rhi = int'(rssi) > int'(rth);
        p_rlo = int'(rssi) < int'(rth);
        p_ghi = int'(agc[6:0]) > int'(gth);
        p_glo = int'(agc[6:0]) < int'(gth);
    endtask

    task automatic chk(bit act, bit expv, string req, int s);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s sel=%0d trig=%0b expected=%0b", req, s, act, expv);
        end
    endtask

    function automatic int clampi(int v, int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic bit flip(bit v, int pct);
        return (int'($urandom_range(0, 99)) < pct) ? !v : v;
    endfunction

    task automatic drive_random();
        fcs_v = ($urandom_range(0, 2) == 0); fcs_ok = $urandom_range(0, 1) != 0;
        sig_v = ($urandom_range(0, 2) == 0); sig_ok = $urandom_range(0, 1) != 0;
        sig_ht = $urandom_range(0, 1) != 0;
        lpre = ($urandom_range(0, 3) == 0); spre = ($urandom_range(0, 3) == 0);
        txs = ($urandom_range(0, 2) == 0); txd = ($urandom_range(0, 2) == 0);
        bb = flip(bb, 30); rf = flip(rf, 30); demod = flip(demod, 30);
        ack = $urandom_range(0, 1) != 0;
        rssi = 11'(clampi(int'(rth) + int'($urandom_range(0, 4)) - 2, 2047));
        agc[7] = flip(agc[7], 30);
        agc[6:0] = 7'(clampi(int'(gth) + int'($urandom_range(0, 4)) - 2, 127));
        amp = 16'(clampi(int'(rth) + int'($urandom_range(0, 4)) - 2, 65535));
    endtask

    // one cycle: check previous prediction, advance history, drive, predict
    task automatic step(int s);
        @(negedge clk);
        chk(trig, exp_q, req_of(exp_sel), exp_sel);
        upd_prev();
        sel = 5'(s);
        drive_random();
        exp_q = exp_ev(s);
        exp_sel = s;
    endtask

    initial begin
        void'($urandom(7));
        rth = 11'd1000; gth = 7'd64;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset holds the trigger low even with strobes asserted
        fcs_v = 1;
        #1;
        chk(trig, 1'b0, "R11", 0);
        fcs_v = 0;
        @(negedge clk);
        chk(trig, 1'b0, "R11", 0);
        // R11: history starts at zero, rssi 0 < 1000 counts as a below-crossing at once
        rssi = '0; agc = '0; sel = 5'd11;
        rst_n = 1'b1;
        exp_q = exp_ev(11); exp_sel = 11;
        for (int pass = 0; pass < 3; pass++) begin
            for (int s = 0; s < 32; s++) begin
                if (s == 0) begin
                    // threshold set at the same edge as the first input set of the pass
                    @(negedge clk);
                    chk(trig, exp_q, req_of(exp_sel), exp_sel);
                    upd_prev();
                    rth = (pass == 0) ? 11'd1000 : (pass == 1) ? 11'd0 : 11'd2047;
                    gth = (pass == 0) ? 7'd64   : (pass == 1) ? 7'd0  : 7'd127;
                    sel = 5'(s);
                    drive_random();
                    exp_q = exp_ev(s); exp_sel = s;
                end
                for (int k = 0; k < 150; k++) step(s);
            end
        end
        // R4 boundary: rssi equal to threshold is neither above nor below
        step(10);
        @(negedge clk);
        chk(trig, exp_q, req_of(exp_sel), exp_sel);
        upd_prev();
        rth = 11'd500; rssi = 11'd500; sel = 5'd10;
        exp_q = exp_ev(10); exp_sel = 10;
        @(negedge clk);
        chk(trig, exp_q, "R4", 10);
        chk(trig, 1'b0, "R4", 10);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2ms;
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule